// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events and clock cycles for software profiling. It holds four event counters and one cycle counter, each 32 bits wide. Each event counter watches one line of an event vector; the line is chosen by that counter's event-type register. The cycle counter can advance on every clock, or once every 64 clocks when the prescale is on.

Software reaches the unit over a single-cycle register bus. A write is taken at the rising clock edge while `we` is high. Read data is a combinational function of `addr` and the current register state. The counters are not mapped one per address. Software first loads a counter index into the selector, then accesses the chosen counter through a data window and a type window. Index 31 stands for the cycle counter. Count enables and interrupt enables each use a pair of registers. Writing a 1 to a bit of the set register turns that bit on, and writing a 1 to a bit of the clear register turns it off.

A counter that wraps sets a sticky overflow flag. The interrupt line is high while any flagged counter also has its interrupt enabled.

Top module: `perfmon_unit`

## Requirements
- R1: Word addresses are: 0 control, 1 count-enable set, 2 count-enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 overflow status, 6 selector, 7 data window, 8 type window, 9 user access. After reset, control reads 0xA53C2000, that is implementor code 0xA5 in bits 31:24, identification code 0x3C in bits 23:16 and the counter count 4 in bits 15:11. Every other register reads 0 after reset, and `irq` is 0.
- R2: In every mask, bit i (0..3) is event counter i and bit 31 is the cycle counter. Writing the count-enable set register ORs the written ones into the enable mask. Writing the clear register removes them. Zero bits change nothing. Both addresses read the same mask, and mask bits other than 31 and 3:0 read as 0.
- R3: The interrupt-enable set/clear pair has the same write-one behaviour, and both of its addresses read the interrupt-enable mask.
- R4: While control bit 0 (global enable) is 0, no counter advances, whatever the enable mask and event lines are.
- R5: An enabled event counter adds one on each clock edge at which its selected event line is high. The line index is the low 3 bits of its type register, and the type window reads back only those 3 bits.
- R6: An enabled cycle counter adds one per clock edge. When control bit 3 is set, it adds one only on every 64th enabled edge.
- R7: Writing control with bit 1 set zeroes all event counters. Writing control with bit 2 set zeroes only the cycle counter and its prescaler. Both bits read back as 0. Control bits 0 and 3 take the written value.
- R8: The data window reads and writes the counter named by the selector. Selector value 31 names the cycle counter. A bus write to a counter takes precedence over counting in that cycle.
- R9: With the selector at 31, the type window reaches an 8-bit cycle-filter register that reads back the low 8 written bits.
- R10: With a selector value other than 0..3 or 31, both windows read 0 and writes through them change no counter and no type register. The selector itself reads back its 5 bits.
- R11: A counter wrapping from all ones to zero sets its bit in the overflow status register. Writing a 1 to a status bit clears it, and writing a 0 leaves it set.
- R12: `irq` is high exactly when some overflow status bit and the matching interrupt-enable bit are both set.
- R13: The user-access register stores only bit 0 and reads 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| we | input | 1 | Write strobe, one write per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt | input | 8 | Event lines, one per possible event source |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is a counter wrap. Counting up from zero would take billions of cycles. The stimulus therefore loads 0xFFFFFFFE into a counter through the data window and pulses its event line for three cycles, so the counter passes through the wrap. The run then checks the interaction between the sticky overflow flag, the interrupt-enable pair and the write-one clear. The divide-by-64 prescale is checked with an exact window of enabled cycles that starts right after a cycle-counter reset, so the expected count of two ticks is known exactly.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int CYC_IDX = 31;
    localparam int SEL_W   = 5;

    typedef enum logic [3:0] {
        A_CTRL    = 4'd0,
        A_CEN_SET = 4'd1,
        A_CEN_CLR = 4'd2,
        A_IEN_SET = 4'd3,
        A_IEN_CLR = 4'd4,
        A_OVF     = 4'd5,
        A_SEL     = 4'd6,
        A_DATA    = 4'd7,
        A_TYPE    = 4'd8,
        A_UACC    = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (ld)  cnt_d = ld_val;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign wrap  = inc && !clr && !ld && (&cnt_q);

    // R5 / R6: a plain increment advances by exactly one
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !ld) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr)      pre_d = '0;
        else if (run) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && !clr && (&pre_q);

    // R6: prescaled ticks never come on adjacent edges
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit #(
    parameter int          NUM_CTR    = 4,
    parameter int          NUM_EVT    = 8,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 4,
    parameter int          FILT_W     = 8,
    parameter int          PRE_W      = 6,
    parameter logic [7:0]  IMPL_CODE  = 8'hA5,
    parameter logic [7:0]  IDENT_CODE = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic              irq
);
    import pmu_pkg::*;

    localparam int EVT_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [DATA_W-1:0] VALID =
        {1'b1, {(DATA_W-1-NUM_CTR){1'b0}}, {NUM_CTR{1'b1}}};

    typedef struct packed {
        logic                            gen_en;
        logic                            div64;
        logic [DATA_W-1:0]               cen;
        logic [DATA_W-1:0]               ien;
        logic [DATA_W-1:0]               ovf;
        logic [SEL_W-1:0]                sel;
        logic [NUM_CTR-1:0][EVT_W-1:0]   etype;
        logic [FILT_W-1:0]               filt;
        logic                            uacc;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ctrl, wr_cen_s, wr_cen_c, wr_ien_s, wr_ien_c;
    logic wr_ovf, wr_sel, wr_data, wr_type, wr_uacc;
    logic sel_cyc;
    logic [DATA_W-1:0] ovf_clr, wrap_vec;

    assign wr_ctrl  = we && (addr == ADDR_W'(A_CTRL));
    assign wr_cen_s = we && (addr == ADDR_W'(A_CEN_SET));
    assign wr_cen_c = we && (addr == ADDR_W'(A_CEN_CLR));
    assign wr_ien_s = we && (addr == ADDR_W'(A_IEN_SET));
    assign wr_ien_c = we && (addr == ADDR_W'(A_IEN_CLR));
    assign wr_ovf   = we && (addr == ADDR_W'(A_OVF));
    assign wr_sel   = we && (addr == ADDR_W'(A_SEL));
    assign wr_data  = we && (addr == ADDR_W'(A_DATA));
    assign wr_type  = we && (addr == ADDR_W'(A_TYPE));
    assign wr_uacc  = we && (addr == ADDR_W'(A_UACC));
    assign sel_cyc  = (r_q.sel == SEL_W'(CYC_IDX));
    assign ovf_clr  = wr_ovf ? (wdata & VALID) : '0;

    // ---- event counters ----
    logic [NUM_CTR-1:0][DATA_W-1:0] ev_cnt;
    logic [NUM_CTR-1:0]             ev_wrap;
    logic                           clr_ev;
    assign clr_ev = wr_ctrl && wdata[1];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ev
        logic inc_i;
        assign inc_i = r_q.gen_en && r_q.cen[i] && evt[r_q.etype[i]];
        pmu_counter #(.W(DATA_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_i),
            .clr    (clr_ev),
            .ld     (wr_data && (r_q.sel == SEL_W'(i))),
            .ld_val (wdata),
            .count  (ev_cnt[i]),
            .wrap   (ev_wrap[i])
        );
    end

    // ---- cycle counter with prescale ----
    logic [DATA_W-1:0] cyc_cnt;
    logic cyc_wrap, cyc_run, pre_tick, clr_cyc;
    assign clr_cyc = wr_ctrl && wdata[2];
    assign cyc_run = r_q.gen_en && r_q.cen[CYC_IDX];

    pmu_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cyc_run && r_q.div64),
        .clr   (clr_cyc),
        .tick  (pre_tick)
    );

    pmu_counter #(.W(DATA_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cyc_run && (!r_q.div64 || pre_tick)),
        .clr    (clr_cyc),
        .ld     (wr_data && sel_cyc),
        .ld_val (wdata),
        .count  (cyc_cnt),
        .wrap   (cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        wrap_vec[NUM_CTR-1:0] = ev_wrap;
        wrap_vec[CYC_IDX]     = cyc_wrap;
    end

    // ---- next-state of the register file ----
    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.gen_en = wdata[0];
            r_d.div64  = wdata[3];
        end
        if (wr_cen_s) r_d.cen = r_q.cen | (wdata & VALID);
        if (wr_cen_c) r_d.cen = r_q.cen & ~(wdata & VALID);
        if (wr_ien_s) r_d.ien = r_q.ien | (wdata & VALID);
        if (wr_ien_c) r_d.ien = r_q.ien & ~(wdata & VALID);
        r_d.ovf = (r_q.ovf & ~ovf_clr) | wrap_vec;
        if (wr_sel)  r_d.sel  = wdata[SEL_W-1:0];
        if (wr_uacc) r_d.uacc = wdata[0];
        if (wr_type) begin
            if (sel_cyc) r_d.filt = wdata[FILT_W-1:0];
            for (int i = 0; i < NUM_CTR; i++)
                if (r_q.sel == SEL_W'(i)) r_d.etype[i] = wdata[EVT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // ---- read mux ----
    logic [DATA_W-1:0] win_data, win_type;
    always_comb begin
        win_data = '0;
        win_type = '0;
        if (sel_cyc) begin
            win_data = cyc_cnt;
            win_type = DATA_W'(r_q.filt);
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (r_q.sel == SEL_W'(i)) begin
                win_data = ev_cnt[i];
                win_type = DATA_W'(r_q.etype[i]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_CTRL):    rdata = {IMPL_CODE, IDENT_CODE, 5'(NUM_CTR), 5'b0,
                                         2'b00, r_q.div64, 2'b00, r_q.gen_en};
            ADDR_W'(A_CEN_SET),
            ADDR_W'(A_CEN_CLR): rdata = r_q.cen;
            ADDR_W'(A_IEN_SET),
            ADDR_W'(A_IEN_CLR): rdata = r_q.ien;
            ADDR_W'(A_OVF):     rdata = r_q.ovf;
            ADDR_W'(A_SEL):     rdata = DATA_W'(r_q.sel);
            ADDR_W'(A_DATA):    rdata = win_data;
            ADDR_W'(A_TYPE):    rdata = win_type;
            ADDR_W'(A_UACC):    rdata = DATA_W'(r_q.uacc);
            default:            rdata = '0;
        endcase
    end

    assign irq = |(r_q.ovf & r_q.ien);

    // R4: with the global enable off and no bus write to counters, counts hold
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.gen_en && !wr_data && !wr_ctrl) |=> ($stable(ev_cnt) && $stable(cyc_cnt)));

    // R11: a status bit not written with 1 stays set
    p_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.ovf & $past(r_q.ovf & ~ovf_clr)) == $past(r_q.ovf & ~ovf_clr)));

    // R7 / R1: reset strobes read as zero, counter count field is fixed
    p_ctrl_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(A_CTRL)) |-> (rdata[2:1] == 2'b00 && rdata[15:11] == 5'(NUM_CTR)));
endmodule

// File: tb/perfmon_unit_test.sv
`timescale 1ns/1ps
module perfmon_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  evt = '0;
    logic        irq;

    always #4 clk = ~clk;

    perfmon_unit uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .evt(evt), .irq(irq)
    );

    localparam logic [3:0] CTRL = 0, CEN_S = 1, CEN_C = 2, IEN_S = 3, IEN_C = 4,
                           OVF = 5, SEL = 6, DATA = 7, TYPE = 8, UACC = 9;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    logic  mon_req = 1'b0;
    bit    done = 0;

    // monitor: pops an expected item and compares it with the design output
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic push_chk(input bit is_irq, input logic [3:0] a,
                            input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.is_irq = is_irq; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        push_chk(1'b0, a, e, tag);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        push_chk(1'b1, CTRL, {31'b0, e}, tag);
    endtask

    task automatic rd_ctr(input logic [4:0] s, input logic [31:0] e, input string tag);
        wr(SEL, {27'b0, s});
        rd(DATA, e, tag);
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        @(posedge clk); #1;
        evt = m;
        repeat (n) @(posedge clk);
        #1 evt = '0;
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(CTRL, 32'hA53C2000, "R1 ctrl");
        rd(CEN_S, 0, "R1 cen");
        rd(IEN_S, 0, "R1 ien");
        rd(OVF, 0, "R1 ovf");
        rd(UACC, 0, "R1 uacc");
        chk_irq(1'b0, "R1 irq");

        // R13 user access bit
        wr(UACC, 32'hFFFF_FFFF);
        rd(UACC, 1, "R13 set");
        wr(UACC, 0);
        rd(UACC, 0, "R13 clear");

        // R2 count enable pair
        wr(CEN_S, 32'h8000_0005);
        rd(CEN_S, 32'h8000_0005, "R2 set");
        rd(CEN_C, 32'h8000_0005, "R2 read clr addr");
        wr(CEN_S, 32'hFFFF_FFF0);
        rd(CEN_S, 32'h8000_0005, "R2 unimpl bits");
        wr(CEN_C, 32'h1);
        rd(CEN_S, 32'h8000_0004, "R2 clear");
        wr(CEN_C, 32'h0);
        rd(CEN_C, 32'h8000_0004, "R2 zero write");

        // R3 interrupt enable pair
        wr(IEN_S, 32'hA);
        rd(IEN_C, 32'hA, "R3 set");
        wr(IEN_C, 32'hFFFF_FFFF);
        rd(IEN_S, 0, "R3 clear");

        // R4 global enable off
        wr(CEN_S, 32'h8000_000F);
        pulse(8'hFF, 10);
        rd_ctr(5'd2, 0, "R4 event ctr");
        rd_ctr(5'd31, 0, "R4 cycle ctr");

        // R5 type selection and counting
        wr(SEL, 0); wr(TYPE, 2);
        wr(SEL, 1); wr(TYPE, 5);
        wr(SEL, 2); wr(TYPE, 32'hFE);
        rd(TYPE, 6, "R5 type low bits");
        wr(SEL, 3); wr(TYPE, 7);
        wr(CTRL, 1);
        pulse(8'h04, 5);
        pulse(8'h20, 3);
        pulse(8'hC0, 4);
        rd_ctr(5'd0, 5, "R5 ctr0");
        rd_ctr(5'd1, 3, "R5 ctr1");
        rd_ctr(5'd2, 4, "R5 ctr2");
        rd_ctr(5'd3, 4, "R5 ctr3");

        // R8 data window write
        wr(SEL, 1); wr(DATA, 100);
        rd(DATA, 100, "R8 ev write");

        // R7 / R8 reset strobes and cycle alias
        wr(CTRL, 0);
        wr(SEL, 31); wr(DATA, 1000);
        rd(DATA, 1000, "R8 cycle alias");
        wr(CTRL, 2);
        rd(DATA, 1000, "R7 cycle kept");
        rd_ctr(5'd1, 0, "R7 ev zeroed");
        wr(SEL, 31); wr(CTRL, 4);
        rd(DATA, 0, "R7 cycle zeroed");
        rd(CTRL, 32'hA53C2000, "R7 strobes read 0");

        // R6 cycle counting, plain then prescaled
        wr(CTRL, 1);
        repeat (8) @(posedge clk);
        wr(CTRL, 0);
        rd(DATA, 10, "R6 per clock");
        wr(CTRL, 4);
        wr(CTRL, 9);
        rd(CTRL, 32'hA53C2009, "R7 bits 0 and 3");
        repeat (125) @(posedge clk);
        wr(CTRL, 0);
        rd(DATA, 2, "R6 div64");

        // R9 cycle filter
        wr(TYPE, 32'hFFFF_FF5A);
        rd(TYPE, 32'h5A, "R9 filter");
        wr(SEL, 0);
        rd(TYPE, 2, "R9 ev type intact");

        // R10 unimplemented selector
        wr(DATA, 77);
        wr(SEL, 7);
        rd(SEL, 7, "R10 sel readback");
        rd(DATA, 0, "R10 data zero");
        rd(TYPE, 0, "R10 type zero");
        wr(DATA, 32'h1234);
        wr(TYPE, 3);
        rd_ctr(5'd0, 77, "R10 ctr0 untouched");
        rd(TYPE, 2, "R10 type untouched");
        rd_ctr(5'd31, 2, "R10 cycle untouched");

        // R11 / R12 overflow and interrupt
        wr(SEL, 0); wr(DATA, 32'hFFFF_FFFE);
        wr(CTRL, 1);
        pulse(8'h04, 3);
        wr(CTRL, 0);
        rd(DATA, 1, "R11 wrapped value");
        rd(OVF, 1, "R11 status set");
        chk_irq(1'b0, "R12 masked");
        wr(IEN_S, 1);
        chk_irq(1'b1, "R12 raised");
        wr(OVF, 0);
        rd(OVF, 1, "R11 zero write keeps");
        wr(IEN_C, 1);
        chk_irq(1'b0, "R12 disabled");
        wr(IEN_S, 1);
        chk_irq(1'b1, "R12 re-enabled");
        wr(OVF, 1);
        rd(OVF, 0, "R11 cleared");
        chk_irq(1'b0, "R12 after clear");

        @(posedge clk);
        done = 1;
        report();
    end
endmodule